// File: doc/BRIEF.md
# Physical Register Free List with Walk Recovery

This block keeps the pool of unallocated physical register indices for an out-of-order rename stage. The pool is a circular queue with a head pointer (next index to hand out) and a tail pointer (next slot to refill). Every cycle, several rename slots may each ask for one destination register. The granted indices are taken from consecutive queue entries, with no gaps between requesting slots. Retiring instructions return their previous mappings through several commit slots, and those indices are appended at the tail.

The queue holds the physical register count minus 32 entries. Thirty-two registers stay bound to the architectural state from reset, so they are never in the pool. A registered flag tells the rename stage whether a full group of requests could be served. The head only moves forward when an external fire input agrees. That input combines the partner list's readiness with downstream readiness.

Misspeculation is undone by walking. While the walk input is high, the head moves back by the number of walked instructions that had a destination. This makes the indices handed out speculatively available again. Walking takes precedence over allocation, and returns arriving during a walk are dropped. A redirect blocks any allocation in its cycle.

Top module: `preg_free_list`

## Requirements
- R1: After a synchronous reset the queue is full. It holds indices 32 up to NUM_PREGS-1 in ascending order starting at the head, and `can_alloc_o` is 1.
- R2: Let k be the number of bits set in `alloc_req_i` below position i. A requesting slot i sees on its field of `alloc_preg_o` the entry k places after the head, in the same cycle. Slot i's field is bits [i*IDX_W +: IDX_W] of `alloc_preg_o`, and slot i's request is bit i of `alloc_req_i`.
- R3: The head advances by the number of set request bits after a rising clock edge at which all of these hold: `alloc_fire_i` = 1, `can_alloc_o` = 1, `walk_i` = 0 and `redirect_i` = 0.
- R4: With `alloc_fire_i` = 0 and no walk, the head does not move. The next cycle offers the same indices.
- R5: With `redirect_i` = 1 and no walk, the head does not move, even when `alloc_fire_i` and `can_alloc_o` are both 1.
- R6: In a cycle with `walk_i` = 1, the head moves back by `step_back_i`. The most recently handed-out indices are offered again, in their original order.
- R7: A walk takes precedence over allocation. Fire, request and `can_alloc_o` do not advance the head in a walk cycle.
- R8: When not walking, each set bit c of `rel_valid_i` appends index c of `rel_preg_i` (bits [c*IDX_W +: IDX_W]) at the tail. Returns are packed in ascending commit-slot order, and they are handed out again in that order after the entries ahead of them.
- R9: Returns presented while `walk_i` = 1 are discarded. They add no entry and do not change the free count.
- R10: `can_alloc_o` is 1 exactly when the free count (tail minus head) is at least RENAME_W. It follows each pointer update one clock later. While it is 0, no allocation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_i | input | 1 | Redirect in progress; suppresses allocation this cycle |
| walk_i | input | 1 | Recovery walk cycle; head steps back, returns dropped |
| step_back_i | input | $clog2(COMMIT_W+1) | Number of walked entries that had a destination |
| alloc_req_i | input | RENAME_W | One allocation request bit per rename slot |
| alloc_fire_i | input | 1 | External permission to consume the requested entries |
| alloc_preg_o | output | RENAME_W*$clog2(NUM_PREGS) | Offered physical index per rename slot |
| can_alloc_o | output | 1 | At least RENAME_W free entries remain |
| rel_valid_i | input | COMMIT_W | One return-valid bit per commit slot |
| rel_preg_i | input | COMMIT_W*$clog2(NUM_PREGS) | Physical index returned per commit slot |

## Verification
The bench builds the list with NUM_PREGS = 48, RENAME_W = 4 and COMMIT_W = 3. This gives a 16-entry queue that four full-width allocations drain completely. The empty case, the point where `can_alloc_o` drops with fewer than four entries left, and the tail wrap are all reached within a few cycles. The three-slot commit side, with a two-bit step-back, allows sparse return patterns such as slots 0 and 2 only, which exercise packing. A long seeded stretch of mixed walks, redirects and returns wraps both pointers many times.

// File: rtl/fl_pkg.sv
package fl_pkg;

  // Registers bound to the architectural state at reset; never in the pool.
  localparam int unsigned FIXED_ARCH = 32;

  typedef enum logic [1:0] {
    HEAD_HOLD = 2'd0,
    HEAD_TAKE = 2'd1,
    HEAD_BACK = 2'd2
  } head_op_e;

endpackage

// File: rtl/fl_prefix.sv
// Exclusive prefix count of a request vector plus its total.
module fl_prefix #(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    bits_i,
  output logic [N*CW-1:0] offs_o,
  output logic [CW-1:0]   total_o
);

  logic [CW-1:0] run [N+1];

  assign run[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_scan
    assign offs_o[i*CW +: CW] = run[i];
    assign run[i+1]           = run[i] + CW'(bits_i[i]);
  end

  assign total_o = run[N];

endmodule

// File: rtl/fl_store.sv
// Circular storage of free indices: packed reads at head, packed writes at tail.
module fl_store #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 7,
  parameter int RW      = 4,
  parameter int CWN     = 4,
  parameter int RCW     = 3,
  parameter int CCW     = 3,
  parameter int BASE    = 32,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        head_lo_i,
  input  logic [AW-1:0]        tail_lo_i,
  input  logic [RW*RCW-1:0]    rd_offs_i,
  input  logic                 wr_en_i,
  input  logic [CWN-1:0]       wr_valid_i,
  input  logic [CWN*CCW-1:0]   wr_offs_i,
  input  logic [CWN*IDX_W-1:0] wr_data_i,
  output logic [RW*IDX_W-1:0]  rd_data_o
);

  logic [IDX_W-1:0] mem_q [ENTRIES];
  logic [AW-1:0]    wr_addr [CWN];
  logic [AW-1:0]    rd_addr [RW];

  for (genvar c = 0; c < CWN; c++) begin : g_waddr
    assign wr_addr[c] = tail_lo_i + AW'(wr_offs_i[c*CCW +: CCW]);
  end

  for (genvar s = 0; s < RW; s++) begin : g_read
    assign rd_addr[s]                 = head_lo_i + AW'(rd_offs_i[s*RCW +: RCW]);
    assign rd_data_o[s*IDX_W +: IDX_W] = mem_q[rd_addr[s]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ENTRIES; k++) begin
        mem_q[k] <= IDX_W'(BASE + k);
      end
    end else if (wr_en_i) begin
      for (int c = 0; c < CWN; c++) begin
        if (wr_valid_i[c]) begin
          mem_q[wr_addr[c]] <= wr_data_i[c*IDX_W +: IDX_W];
        end
      end
    end
  end

endmodule

// File: rtl/fl_ptr_ctrl.sv
// Head/tail pointers with wrap bit and the registered group-availability flag.
module fl_ptr_ctrl
  import fl_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int RW      = 4,
  parameter int RCW     = 3,
  parameter int CCW     = 3,
  parameter int SBW     = 3,
  parameter int PTR_W   = $clog2(ENTRIES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             walk_i,
  input  logic [SBW-1:0]   step_back_i,
  input  logic             redirect_i,
  input  logic             fire_i,
  input  logic [RCW-1:0]   take_cnt_i,
  input  logic [CCW-1:0]   rel_cnt_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             rel_en_o,
  output logic             can_alloc_o
);

  logic [PTR_W-1:0] head_q, head_n;
  logic [PTR_W-1:0] tail_q, tail_n;
  logic [PTR_W-1:0] count_n;
  logic             can_q;
  head_op_e         op;

  always_comb begin
    if (walk_i) begin
      op = HEAD_BACK;
    end else if (fire_i && can_q && !redirect_i) begin
      op = HEAD_TAKE;
    end else begin
      op = HEAD_HOLD;
    end
  end

  always_comb begin
    unique case (op)
      HEAD_BACK: head_n = head_q - PTR_W'(step_back_i);
      HEAD_TAKE: head_n = head_q + PTR_W'(take_cnt_i);
      default:   head_n = head_q;
    endcase
  end

  assign rel_en_o = !walk_i;
  assign tail_n   = rel_en_o ? tail_q + PTR_W'(rel_cnt_i) : tail_q;
  assign count_n  = tail_n - head_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= PTR_W'(ENTRIES);
      can_q  <= (ENTRIES >= RW);
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      can_q  <= (count_n >= PTR_W'(RW));
    end
  end

  assign head_o      = head_q;
  assign tail_o      = tail_q;
  assign can_alloc_o = can_q;

endmodule

// File: rtl/preg_free_list.sv
module preg_free_list
  import fl_pkg::*;
#(
  parameter int NUM_PREGS = 96,
  parameter int RENAME_W  = 4,
  parameter int COMMIT_W  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   redirect_i,
  input  logic                                   walk_i,
  input  logic [$clog2(COMMIT_W+1)-1:0]          step_back_i,
  input  logic [RENAME_W-1:0]                    alloc_req_i,
  input  logic                                   alloc_fire_i,
  output logic [RENAME_W*$clog2(NUM_PREGS)-1:0]  alloc_preg_o,
  output logic                                   can_alloc_o,
  input  logic [COMMIT_W-1:0]                    rel_valid_i,
  input  logic [COMMIT_W*$clog2(NUM_PREGS)-1:0]  rel_preg_i
);

  localparam int ENTRIES = NUM_PREGS - FIXED_ARCH;
  localparam int IDX_W   = $clog2(NUM_PREGS);
  localparam int AW      = $clog2(ENTRIES);
  localparam int PTR_W   = AW + 1;
  localparam int RCW     = $clog2(RENAME_W + 1);
  localparam int CCW     = $clog2(COMMIT_W + 1);
  localparam int SBW     = CCW;

  logic [RENAME_W*RCW-1:0] take_offs;
  logic [RCW-1:0]          take_cnt;
  logic [COMMIT_W*CCW-1:0] rel_offs;
  logic [CCW-1:0]          rel_cnt;
  logic [PTR_W-1:0]        head_q;
  logic [PTR_W-1:0]        tail_q;
  logic                    rel_en;

  fl_prefix #(.N(RENAME_W), .CW(RCW)) u_take_scan (
    .bits_i  (alloc_req_i),
    .offs_o  (take_offs),
    .total_o (take_cnt)
  );

  fl_prefix #(.N(COMMIT_W), .CW(CCW)) u_rel_scan (
    .bits_i  (rel_valid_i),
    .offs_o  (rel_offs),
    .total_o (rel_cnt)
  );

  fl_ptr_ctrl #(
    .ENTRIES (ENTRIES),
    .RW      (RENAME_W),
    .RCW     (RCW),
    .CCW     (CCW),
    .SBW     (SBW),
    .PTR_W   (PTR_W)
  ) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .walk_i      (walk_i),
    .step_back_i (step_back_i),
    .redirect_i  (redirect_i),
    .fire_i      (alloc_fire_i),
    .take_cnt_i  (take_cnt),
    .rel_cnt_i   (rel_cnt),
    .head_o      (head_q),
    .tail_o      (tail_q),
    .rel_en_o    (rel_en),
    .can_alloc_o (can_alloc_o)
  );

  fl_store #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .RW      (RENAME_W),
    .CWN     (COMMIT_W),
    .RCW     (RCW),
    .CCW     (CCW),
    .BASE    (FIXED_ARCH),
    .AW      (AW)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .head_lo_i  (head_q[AW-1:0]),
    .tail_lo_i  (tail_q[AW-1:0]),
    .rd_offs_i  (take_offs),
    .wr_en_i    (rel_en),
    .wr_valid_i (rel_valid_i),
    .wr_offs_i  (rel_offs),
    .wr_data_i  (rel_preg_i),
    .rd_data_o  (alloc_preg_o)
  );

endmodule

// File: rtl/preg_free_list_chk.sv
module preg_free_list_chk #(
  parameter int NUM_PREGS = 96,
  parameter int RENAME_W  = 4,
  parameter int COMMIT_W  = 4,
  parameter int PTR_W     = 7
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  redirect_i,
  input logic                                  walk_i,
  input logic [$clog2(COMMIT_W+1)-1:0]         step_back_i,
  input logic [RENAME_W-1:0]                   alloc_req_i,
  input logic                                  alloc_fire_i,
  input logic [RENAME_W*$clog2(NUM_PREGS)-1:0] alloc_preg_o,
  input logic                                  can_alloc_o,
  input logic [COMMIT_W-1:0]                   rel_valid_i,
  input logic [PTR_W-1:0]                      head_q,
  input logic [PTR_W-1:0]                      tail_q
);

  localparam int ENTRIES = NUM_PREGS - 32;
  localparam int IDX_W   = $clog2(NUM_PREGS);

  logic [PTR_W-1:0] fill;
  assign fill = tail_q - head_q;

  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    fill <= PTR_W'(ENTRIES));

  p_can_flag_r10: assert property (@(posedge clk) disable iff (rst)
    can_alloc_o == (fill >= PTR_W'(RENAME_W)));

  p_walk_back_r6: assert property (@(posedge clk) disable iff (rst)
    (!rst && walk_i) |=> head_q == $past(head_q) - PTR_W'($past(step_back_i)));

  p_walk_first_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && walk_i && alloc_fire_i && can_alloc_o && (step_back_i == '0))
      |=> $stable(head_q));

  p_no_fire_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !walk_i && !alloc_fire_i) |=> $stable(head_q));

  p_redirect_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !walk_i && redirect_i) |=> $stable(head_q));

  p_take_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !walk_i && !redirect_i && alloc_fire_i && can_alloc_o)
      |=> head_q == $past(head_q) + PTR_W'($countones($past(alloc_req_i))));

  p_rel_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && walk_i) |=> $stable(tail_q));

  p_rel_adv_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && !walk_i)
      |=> tail_q == $past(tail_q) + PTR_W'($countones($past(rel_valid_i))));

  for (genvar s = 0; s < RENAME_W; s++) begin : g_range
    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
      (alloc_req_i[s] && can_alloc_o)
        |-> (alloc_preg_o[s*IDX_W +: IDX_W] >= IDX_W'(32)));
  end

endmodule

bind preg_free_list preg_free_list_chk #(
  .NUM_PREGS (NUM_PREGS),
  .RENAME_W  (RENAME_W),
  .COMMIT_W  (COMMIT_W),
  .PTR_W     (PTR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .redirect_i   (redirect_i),
  .walk_i       (walk_i),
  .step_back_i  (step_back_i),
  .alloc_req_i  (alloc_req_i),
  .alloc_fire_i (alloc_fire_i),
  .alloc_preg_o (alloc_preg_o),
  .can_alloc_o  (can_alloc_o),
  .rel_valid_i  (rel_valid_i),
  .head_q       (head_q),
  .tail_q       (tail_q)
);

// File: tb/preg_free_list_test.sv
`timescale 1ns/1ps
module preg_free_list_test;

  localparam int NPR   = 48;
  localparam int RW    = 4;
  localparam int CWN   = 3;
  localparam int IDX_W = $clog2(NPR);
  localparam int SBW   = $clog2(CWN + 1);
  localparam int NENT  = NPR - 32;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 redirect_i = 1'b0;
  logic                 walk_i = 1'b0;
  logic [SBW-1:0]       step_back_i = '0;
  logic [RW-1:0]        alloc_req_i = '0;
  logic                 alloc_fire_i = 1'b0;
  logic [RW*IDX_W-1:0]  alloc_preg_o;
  logic                 can_alloc_o;
  logic [CWN-1:0]       rel_valid_i = '0;
  logic [CWN*IDX_W-1:0] rel_preg_i = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int free_q[$];
  int hist_q[$];
  int e_slot[$];
  int e_val[$];
  string e_tag[$];

  always #2.5 clk = ~clk;

  preg_free_list #(.NUM_PREGS(NPR), .RENAME_W(RW), .COMMIT_W(CWN)) uut (
    .clk          (clk),
    .rst          (rst),
    .redirect_i   (redirect_i),
    .walk_i       (walk_i),
    .step_back_i  (step_back_i),
    .alloc_req_i  (alloc_req_i),
    .alloc_fire_i (alloc_fire_i),
    .alloc_preg_o (alloc_preg_o),
    .can_alloc_o  (can_alloc_o),
    .rel_valid_i  (rel_valid_i),
    .rel_preg_i   (rel_preg_i)
  );

  // Monitor: compares the outputs before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (e_slot.size() > 0) begin
        automatic int    s = e_slot.pop_front();
        automatic int    v = e_val.pop_front();
        automatic string t = e_tag.pop_front();
        automatic int    a;
        if (s < 0) a = int'(can_alloc_o);
        else       a = int'(alloc_preg_o[s*IDX_W +: IDX_W]);
        checks++;
        if (a != v) begin
          fails++;
          $display("FAIL %s slot=%0d actual=%0d expected=%0d", t, s, a, v);
        end
      end
    end
  end

  // Driver: one cycle of stimulus, expectations queued for the monitor.
  task automatic cyc(input logic [RW-1:0] req, input logic fire, input logic redir,
                     input logic walk, input int sb, input logic [CWN-1:0] relv,
                     input string tag);
    automatic bit exp_can;
    automatic int k = 0;
    automatic logic [CWN*IDX_W-1:0] rdata = '0;
    automatic logic [CWN-1:0] rv = relv;
    @(negedge clk);
    exp_can = (free_q.size() >= RW);
    e_slot.push_back(-1); e_val.push_back(int'(exp_can)); e_tag.push_back(tag);
    if (exp_can) begin
      for (int i = 0; i < RW; i++) begin
        if (req[i]) begin
          e_slot.push_back(i); e_val.push_back(free_q[k]); e_tag.push_back(tag);
          k++;
        end
      end
    end
    for (int c = 0; c < CWN; c++) begin
      if (rv[c]) begin
        if (walk) rdata[c*IDX_W +: IDX_W] = IDX_W'(40 + c);
        else if (hist_q.size() > 0) rdata[c*IDX_W +: IDX_W] = IDX_W'(hist_q.pop_front());
        else rv[c] = 1'b0;
      end
    end
    alloc_req_i  = req;
    alloc_fire_i = fire;
    redirect_i   = redir;
    walk_i       = walk;
    step_back_i  = SBW'(sb);
    rel_valid_i  = rv;
    rel_preg_i   = rdata;
    if (walk) begin
      for (int j = 0; j < sb; j++) free_q.push_front(hist_q.pop_back());
    end else begin
      if (fire && exp_can && !redir) begin
        for (int j = 0; j < k; j++) hist_q.push_back(free_q.pop_front());
      end
      for (int c = 0; c < CWN; c++) begin
        if (rv[c]) free_q.push_back(int'(rdata[c*IDX_W +: IDX_W]));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, run hung: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) free_q.push_back(32 + i);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    cyc(4'b1111, 0, 0, 0, 0, 3'b000, "R1");          // 32..35, full after reset
    cyc(4'b1010, 1, 0, 0, 0, 3'b000, "R2");          // packed: slot1=32, slot3=33
    cyc(4'b1111, 0, 0, 0, 0, 3'b000, "R3");          // head moved by 2: 34..37
    cyc(4'b1111, 0, 0, 0, 0, 3'b000, "R4");          // no fire: still 34..37
    cyc(4'b1111, 1, 1, 0, 0, 3'b000, "R5");          // redirect blocks
    cyc(4'b0001, 0, 0, 0, 0, 3'b000, "R5");          // still 34
    cyc(4'b1111, 1, 0, 1, 2, 3'b011, "R7");          // walk beats fire, returns dropped
    cyc(4'b1111, 0, 0, 0, 0, 3'b000, "R6");          // 32..35 offered again
    cyc(4'b1111, 1, 0, 0, 0, 3'b000, "R6");
    cyc(4'b1111, 1, 0, 0, 0, 3'b000, "R3");
    cyc(4'b1111, 1, 0, 0, 0, 3'b000, "R3");
    cyc(4'b1111, 1, 0, 0, 0, 3'b000, "R3");          // list now empty
    cyc(4'b1111, 1, 0, 0, 0, 3'b000, "R9 R10");      // empty: flag low
    cyc(4'b0000, 0, 0, 0, 0, 3'b101, "R10");         // return 32 (slot0), 33 (slot2)
    cyc(4'b0000, 0, 0, 0, 0, 3'b010, "R10");         // return 34
    cyc(4'b1111, 1, 0, 0, 0, 3'b001, "R10");         // 3 free: low, fire ignored; return 35
    cyc(4'b1111, 1, 0, 0, 0, 3'b000, "R8");          // 32,33,34,35 in return order

    for (int n = 0; n < 3000; n++) begin
      automatic logic [RW-1:0]  rq = RW'($urandom);
      automatic logic           fr = ($urandom % 4) != 0;
      automatic logic           rd = ($urandom % 8) == 0;
      automatic logic           wk = ($urandom % 8) == 0;
      automatic int             sb = 0;
      automatic logic [CWN-1:0] rv = CWN'($urandom);
      if (wk) begin
        sb = $urandom % (CWN + 1);
        if (sb > hist_q.size()) sb = hist_q.size();
      end
      cyc(rq, fr, rd, wk, sb, rv, "R2 R3 R6 R8 R9");
    end

    cyc(4'b0000, 0, 0, 0, 0, 3'b000, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule